// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves data for one DMA channel. Software programs a source address, a destination address and a byte count through a small word-wide register port, picks a transfer mode and an address behaviour for each end, and then sets a trigger bit. The engine works in beats. Each beat reads one word over a generic bus master port into a one-word holding buffer, and then writes that buffer to the destination. It tracks the current source address, destination address and remaining byte count. It raises status flags for completion, reaching half of the programmed count, a wrap-around restart and a bus error.

Three modes are supported: memory-to-memory, peripheral-to-memory and memory-to-peripheral. In the two peripheral modes a beat starts only while the peripheral requests service. The engine acknowledges each beat once its write has finished, and the peripheral transfer width sets the address step. In wrap-around mode the channel reloads itself from the programmed values each time the count runs out, and keeps running until software clears the enable.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset every register reads 0, `bus_req` is low and `irq` is low. Register indices on `reg_addr`: 0 control, 1 programmed source, 2 programmed destination, 3 programmed byte count, 4 interrupt enable, 5 status, 6 current source, 7 current destination, 8 current byte count.
- R2: Control bit positions are: enable [0], soft reset [1], mode [3:2], source direction [5:4], destination direction [7:6], peripheral width [9:8] and trigger [10]. The mode codes are 00 memory-to-memory, 01 peripheral-to-memory and 10 memory-to-peripheral; 11 is reserved and acts as memory-to-memory. In the peripheral modes the width codes are 00 word (4 bytes), 01 byte and 10 half-word (2 bytes); 11 acts as word. Memory-to-memory always steps by 4. Each beat is one bus read followed by one bus write, and the write carries the data returned by that read.
- R3: The direction codes are 00 increment, 10 fixed and 11 wrap-around; 01 is reserved and acts as increment. A fixed address never changes during a run. An increment or wrap address advances by the step after each completed access at its end: the read for the source, the write for the destination.
- R4: The current byte count changes only when a destination write completes. It then falls by the step, and stops at 0 rather than going below it. When the count is 0 outside wrap mode, the done flag (status bit 1) is set, the trigger bit clears and the engine goes idle.
- R5: In the peripheral modes a beat starts only while `per_req` is high, and `per_ack` pulses once for each completed destination write. `per_ack` never pulses in memory-to-memory mode.
- R6: Wrap mode is in force when either direction code is 11. When the count reaches 0 in wrap mode, both current addresses and the count reload from the programmed values, the wrap flag (status bit 2) is set, and the next run starts without a new trigger.
- R7: The half-count flag (status bit 3) is set when a completed write leaves a remaining count equal to the programmed count divided by two, rounded down.
- R8: While the enable is low, a trigger starts nothing and the bus stays idle. If the enable is cleared during a run, the bus access in progress completes. Data still held in the buffer is then not written, and the engine goes idle.
- R9: An error response on the bus sets the abort flag (status bit 0), clears the trigger and idles the engine. No further transfer starts until a soft reset has been done.
- R10: A soft reset clears the engine state, the current addresses, the current count and the error lock. It leaves the other control fields unchanged, and the soft reset bit clears itself after RST_CYC cycles.
- R11: Writing 1 to a status bit clears it and writing 0 has no effect. When a flag is set and cleared in the same cycle, the set wins. `irq` is high while any status flag and its matching enable bit (same bit position) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Peripheral beat completed |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access byte address |
| bus_wdata | output | DW | Write data |
| bus_size | output | 2 | Access size as log2 of bytes |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access ended with an error |
| bus_rdata | input | DW | Read data |

## Verification
The engine can set a status flag in the same cycle that software writes 1 to clear that same flag. The bench provokes this with a wrap-mode run of one beat per lap, which sets the wrap flag every few cycles. Meanwhile the bench holds a clear write to the wrap bit on every cycle. The flag must still be seen set between clears: a design where the clear wins would always read it as 0.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
   localparam logic [1:0] MODE_M2M = 2'b00;
   localparam logic [1:0] MODE_P2M = 2'b01;
   localparam logic [1:0] MODE_M2P = 2'b10;

   localparam logic [1:0] DIR_FIX  = 2'b10;
   localparam logic [1:0] DIR_WRAP = 2'b11;

   localparam logic [1:0] WID_BYTE = 2'b01;
   localparam logic [1:0] WID_HALF = 2'b10;

   localparam int CB_EN   = 0;
   localparam int CB_SRST = 1;
   localparam int CB_MODE = 2;
   localparam int CB_SDIR = 4;
   localparam int CB_DDIR = 6;
   localparam int CB_WID  = 8;
   localparam int CB_TRIG = 10;

   localparam int NSTS     = 4;
   localparam int SB_ABORT = 0;
   localparam int SB_DONE  = 1;
   localparam int SB_WRAP  = 2;
   localparam int SB_HALF  = 3;

   localparam int RI_CTRL = 0;
   localparam int RI_SRC  = 1;
   localparam int RI_DST  = 2;
   localparam int RI_CNT  = 3;
   localparam int RI_IEN  = 4;
   localparam int RI_STS  = 5;
   localparam int RI_CSRC = 6;
   localparam int RI_CDST = 7;
   localparam int RI_CCNT = 8;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_READ  = 2'd2,
      ST_WRITE = 2'd3
   } eng_state_t;
endpackage

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
module dma_addr_gen #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic [1:0]    dir,
   input  logic [2:0]    step,
   output logic [AW-1:0] cur
);
   import dma_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cur <= '0;
      else if (clr)                   cur <= '0;
      else if (load)                  cur <= base;
      else if (adv && dir != DIR_FIX) cur <= cur + AW'(step);
   end
endmodule

// File: rtl/dma_regs.sv
`timescale 1ns/1ps
module dma_regs #(
   parameter int AW      = 32,
   parameter int CW      = 16,
   parameter int RAW     = 4,
   parameter int RST_CYC = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [RAW-1:0]           reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   output logic                     cfg_en,
   output logic                     cfg_srst,
   output logic [1:0]               cfg_mode,
   output logic [1:0]               cfg_sdir,
   output logic [1:0]               cfg_ddir,
   output logic [1:0]               cfg_wid,
   output logic                     cfg_trig,
   output logic [AW-1:0]            prog_src,
   output logic [AW-1:0]            prog_dst,
   output logic [CW-1:0]            prog_cnt,
   output logic [dma_pkg::NSTS-1:0] sts,
   output logic                     irq,
   input  logic [AW-1:0]            cur_src,
   input  logic [AW-1:0]            cur_dst,
   input  logic [CW-1:0]            cur_cnt,
   input  logic [dma_pkg::NSTS-1:0] sts_set,
   input  logic                     clr_trig
);
   import dma_pkg::*;

   localparam int SCW = $clog2(RST_CYC + 1);

   logic [NSTS-1:0] ien;
   logic [SCW-1:0]  srst_cnt;
   logic            wr_ctrl, wr_sts;

   assign wr_ctrl = reg_we && (reg_addr == RAW'(RI_CTRL));
   assign wr_sts  = reg_we && (reg_addr == RAW'(RI_STS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en   <= 1'b0;
         cfg_mode <= '0;
         cfg_sdir <= '0;
         cfg_ddir <= '0;
         cfg_wid  <= '0;
         cfg_trig <= 1'b0;
         prog_src <= '0;
         prog_dst <= '0;
         prog_cnt <= '0;
         ien      <= '0;
      end else begin
         if (wr_ctrl) begin
            cfg_en   <= reg_wdata[CB_EN];
            cfg_mode <= reg_wdata[CB_MODE +: 2];
            cfg_sdir <= reg_wdata[CB_SDIR +: 2];
            cfg_ddir <= reg_wdata[CB_DDIR +: 2];
            cfg_wid  <= reg_wdata[CB_WID +: 2];
            cfg_trig <= reg_wdata[CB_TRIG] && !clr_trig;
         end else if (clr_trig) begin
            cfg_trig <= 1'b0;
         end
         if (reg_we && reg_addr == RAW'(RI_SRC)) prog_src <= reg_wdata[AW-1:0];
         if (reg_we && reg_addr == RAW'(RI_DST)) prog_dst <= reg_wdata[AW-1:0];
         if (reg_we && reg_addr == RAW'(RI_CNT)) prog_cnt <= reg_wdata[CW-1:0];
         if (reg_we && reg_addr == RAW'(RI_IEN)) ien      <= reg_wdata[NSTS-1:0];
      end
   end

   // Soft reset bit: set by software, dropped by hardware after RST_CYC cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_srst <= 1'b0;
         srst_cnt <= '0;
      end else if (cfg_srst) begin
         if (srst_cnt == SCW'(RST_CYC - 1)) begin
            cfg_srst <= 1'b0;
            srst_cnt <= '0;
         end else begin
            srst_cnt <= srst_cnt + 1'b1;
         end
      end else if (wr_ctrl && reg_wdata[CB_SRST]) begin
         cfg_srst <= 1'b1;
      end
   end

   // Status: write-one-to-clear, a hardware set in the same cycle wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts <= '0;
      else        sts <= (sts & ~(wr_sts ? reg_wdata[NSTS-1:0] : '0)) | sts_set;
   end

   assign irq = |(sts & ien);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RAW'(RI_CTRL): begin
            reg_rdata[CB_EN]       = cfg_en;
            reg_rdata[CB_SRST]     = cfg_srst;
            reg_rdata[CB_MODE +: 2] = cfg_mode;
            reg_rdata[CB_SDIR +: 2] = cfg_sdir;
            reg_rdata[CB_DDIR +: 2] = cfg_ddir;
            reg_rdata[CB_WID +: 2]  = cfg_wid;
            reg_rdata[CB_TRIG]     = cfg_trig;
         end
         RAW'(RI_SRC):  reg_rdata[AW-1:0]   = prog_src;
         RAW'(RI_DST):  reg_rdata[AW-1:0]   = prog_dst;
         RAW'(RI_CNT):  reg_rdata[CW-1:0]   = prog_cnt;
         RAW'(RI_IEN):  reg_rdata[NSTS-1:0] = ien;
         RAW'(RI_STS):  reg_rdata[NSTS-1:0] = sts;
         RAW'(RI_CSRC): reg_rdata[AW-1:0]   = cur_src;
         RAW'(RI_CDST): reg_rdata[AW-1:0]   = cur_dst;
         RAW'(RI_CCNT): reg_rdata[CW-1:0]   = cur_cnt;
         default:       reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_engine.sv
`timescale 1ns/1ps
module dma_engine #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     srst,
   input  logic                     en,
   input  logic                     trig,
   input  logic [1:0]               mode,
   input  logic [1:0]               sdir,
   input  logic [1:0]               ddir,
   input  logic [1:0]               wid,
   input  logic [AW-1:0]            prog_src,
   input  logic [AW-1:0]            prog_dst,
   input  logic [CW-1:0]            prog_cnt,
   input  logic                     per_req,
   output logic                     per_ack,
   output logic                     bus_req,
   output logic                     bus_we,
   output logic [AW-1:0]            bus_addr,
   output logic [DW-1:0]            bus_wdata,
   output logic [1:0]               bus_size,
   input  logic                     bus_ack,
   input  logic                     bus_err,
   input  logic [DW-1:0]            bus_rdata,
   output logic [AW-1:0]            cur_src,
   output logic [AW-1:0]            cur_dst,
   output logic [CW-1:0]            cur_cnt,
   output logic [dma_pkg::NSTS-1:0] sts_set,
   output logic                     clr_trig,
   output logic                     load
);
   import dma_pkg::*;

   localparam int NEND = 2;   // end 0 = source, end 1 = destination

   eng_state_t      state_q, state_d;
   logic            locked_q;
   logic [DW-1:0]   buf_q;
   logic            periph, wrap_mode, cnt_zero;
   logic            start, reload, finish, abort, rd_ok, wr_ok;
   logic [2:0]      step;
   logic [CW-1:0]   cnt_dec;

   logic [AW-1:0]   end_base [NEND];
   logic [AW-1:0]   end_cur  [NEND];
   logic [1:0]      end_dir  [NEND];
   logic            end_adv  [NEND];

   assign periph    = (mode == MODE_P2M) || (mode == MODE_M2P);
   assign wrap_mode = (sdir == DIR_WRAP) || (ddir == DIR_WRAP);
   assign cnt_zero  = (cur_cnt == '0);

   always_comb begin
      if (!periph)               bus_size = 2'd2;
      else if (wid == WID_BYTE)  bus_size = 2'd0;
      else if (wid == WID_HALF)  bus_size = 2'd1;
      else                       bus_size = 2'd2;
   end
   assign step = 3'd1 << bus_size;

   assign start  = (state_q == ST_IDLE) && en && trig && !locked_q;
   assign reload = (state_q == ST_CHECK) && en && cnt_zero && wrap_mode;
   assign finish = (state_q == ST_CHECK) && en && cnt_zero && !wrap_mode;
   assign abort  = ((state_q == ST_READ) || (state_q == ST_WRITE)) && bus_err;
   assign rd_ok  = (state_q == ST_READ)  && bus_ack && !bus_err;
   assign wr_ok  = (state_q == ST_WRITE) && bus_ack && !bus_err;
   assign load   = start || reload;

   assign cnt_dec = (cur_cnt > CW'(step)) ? cur_cnt - CW'(step) : '0;

   always_comb begin
      sts_set           = '0;
      sts_set[SB_ABORT] = abort;
      sts_set[SB_DONE]  = finish;
      sts_set[SB_WRAP]  = reload;
      sts_set[SB_HALF]  = wr_ok && (cnt_dec == (prog_cnt >> 1));
   end
   assign clr_trig = finish || abort;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (start) state_d = ST_CHECK;
         ST_CHECK: begin
            if (!en)                          state_d = ST_IDLE;
            else if (cnt_zero)                state_d = wrap_mode ? ST_CHECK : ST_IDLE;
            else if (!periph || per_req)      state_d = ST_READ;
         end
         ST_READ: begin
            if (bus_err)      state_d = ST_IDLE;
            else if (bus_ack) state_d = en ? ST_WRITE : ST_IDLE;
         end
         ST_WRITE: begin
            if (bus_err)      state_d = ST_IDLE;
            else if (bus_ack) state_d = ST_CHECK;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         locked_q <= 1'b0;
         buf_q    <= '0;
         cur_cnt  <= '0;
      end else if (srst) begin
         state_q  <= ST_IDLE;
         locked_q <= 1'b0;
         buf_q    <= '0;
         cur_cnt  <= '0;
      end else begin
         state_q <= state_d;
         if (abort) locked_q <= 1'b1;
         if (rd_ok) buf_q <= bus_rdata;
         if (load)       cur_cnt <= prog_cnt;
         else if (wr_ok) cur_cnt <= cnt_dec;
      end
   end

   assign end_base[0] = prog_src;
   assign end_base[1] = prog_dst;
   assign end_dir[0]  = sdir;
   assign end_dir[1]  = ddir;
   assign end_adv[0]  = rd_ok;
   assign end_adv[1]  = wr_ok;

   for (genvar e = 0; e < NEND; e++) begin : g_end
      dma_addr_gen #(.AW(AW)) u_addr (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (srst),
         .load (load),
         .base (end_base[e]),
         .adv  (end_adv[e]),
         .dir  (end_dir[e]),
         .step (step),
         .cur  (end_cur[e])
      );
   end

   assign cur_src   = end_cur[0];
   assign cur_dst   = end_cur[1];
   assign bus_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign bus_we    = (state_q == ST_WRITE);
   assign bus_addr  = bus_we ? cur_dst : cur_src;
   assign bus_wdata = buf_q;
   assign per_ack   = wr_ok && periph;
endmodule

// File: rtl/dma_xfer_channel.sv
`timescale 1ns/1ps
module dma_xfer_channel #(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int CW      = 16,
   parameter int RAW     = 4,
   parameter int RST_CYC = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [RAW-1:0] reg_addr,
   input  logic [31:0]    reg_wdata,
   output logic [31:0]    reg_rdata,
   output logic           irq,
   input  logic           per_req,
   output logic           per_ack,
   output logic           bus_req,
   output logic           bus_we,
   output logic [AW-1:0]  bus_addr,
   output logic [DW-1:0]  bus_wdata,
   output logic [1:0]     bus_size,
   input  logic           bus_ack,
   input  logic           bus_err,
   input  logic [DW-1:0]  bus_rdata
);
   import dma_pkg::*;

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("AW must lie in 8..32");
   end
   if (DW != 32) begin : g_bad_dw
      $error("DW must be 32");
   end
   if (CW < 3 || CW > 24) begin : g_bad_cw
      $error("CW must lie in 3..24");
   end
   if (RAW < 4) begin : g_bad_raw
      $error("RAW must be at least 4");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be at least 1");
   end

   logic            cfg_en, cfg_srst, cfg_trig;
   logic [1:0]      cfg_mode, cfg_sdir, cfg_ddir, cfg_wid;
   logic [AW-1:0]   prog_src, prog_dst, cur_src, cur_dst;
   logic [CW-1:0]   prog_cnt, cur_cnt;
   logic [NSTS-1:0] sts, sts_set;
   logic            clr_trig, eng_load;

   dma_regs #(.AW(AW), .CW(CW), .RAW(RAW), .RST_CYC(RST_CYC)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .cfg_en   (cfg_en),
      .cfg_srst (cfg_srst),
      .cfg_mode (cfg_mode),
      .cfg_sdir (cfg_sdir),
      .cfg_ddir (cfg_ddir),
      .cfg_wid  (cfg_wid),
      .cfg_trig (cfg_trig),
      .prog_src (prog_src),
      .prog_dst (prog_dst),
      .prog_cnt (prog_cnt),
      .sts      (sts),
      .irq      (irq),
      .cur_src  (cur_src),
      .cur_dst  (cur_dst),
      .cur_cnt  (cur_cnt),
      .sts_set  (sts_set),
      .clr_trig (clr_trig)
   );

   dma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (cfg_srst),
      .en       (cfg_en),
      .trig     (cfg_trig),
      .mode     (cfg_mode),
      .sdir     (cfg_sdir),
      .ddir     (cfg_ddir),
      .wid      (cfg_wid),
      .prog_src (prog_src),
      .prog_dst (prog_dst),
      .prog_cnt (prog_cnt),
      .per_req  (per_req),
      .per_ack  (per_ack),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_size (bus_size),
      .bus_ack  (bus_ack),
      .bus_err  (bus_err),
      .bus_rdata(bus_rdata),
      .cur_src  (cur_src),
      .cur_dst  (cur_dst),
      .cur_cnt  (cur_cnt),
      .sts_set  (sts_set),
      .clr_trig (clr_trig),
      .load     (eng_load)
   );
endmodule

// File: rtl/dma_chk.sv
`timescale 1ns/1ps
module dma_chk #(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     en,
   input logic                     srst,
   input logic                     trig,
   input logic [1:0]               sdir,
   input logic                     load,
   input logic                     ev_done,
   input logic [dma_pkg::NSTS-1:0] sts,
   input logic                     bus_req,
   input logic                     bus_we,
   input logic                     bus_ack,
   input logic                     bus_err,
   input logic [AW-1:0]            cur_src,
   input logic [CW-1:0]            cur_cnt
);
   import dma_pkg::*;

   a_r8_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !bus_req) |=> !bus_req);

   a_r8_drop_held_data: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_ack && !bus_err && !en) |=> !bus_req);

   a_r4_count_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_req && bus_we && bus_ack) && !load && !srst) |=> $stable(cur_cnt));

   a_r3_fixed_src_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_ack && sdir == DIR_FIX && !load && !srst) |=> $stable(cur_src));

   a_r9_err_stops_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_err) |=> !bus_req);

   a_r4_trig_clears_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |=> !trig);

   a_r11_done_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |=> sts[SB_DONE]);
endmodule

bind dma_xfer_channel dma_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (cfg_en),
   .srst   (cfg_srst),
   .trig   (cfg_trig),
   .sdir   (cfg_sdir),
   .load   (eng_load),
   .ev_done(sts_set[dma_pkg::SB_DONE]),
   .sts    (sts),
   .bus_req(bus_req),
   .bus_we (bus_we),
   .bus_ack(bus_ack),
   .bus_err(bus_err),
   .cur_src(cur_src),
   .cur_cnt(cur_cnt)
);

// File: tb/dma_xfer_channel_tb.sv
`timescale 1ns/1ps
module dma_xfer_channel_tb;
   localparam logic [31:0] PAT = 32'hC0DE_0000;

   typedef struct packed {
      logic [1:0]  mode;
      logic [1:0]  sdir;
      logic [1:0]  ddir;
      logic [1:0]  wid;
      logic [31:0] src;
      logic [31:0] dst;
      logic [15:0] cnt;
      logic [31:0] esrc;
      logic [31:0] edst;
      logic [7:0]  ebeats;
      logic        ehalf;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{2'b00, 2'b00, 2'b00, 2'b00, 32'h100, 32'h200, 16'd16, 32'h110, 32'h210, 8'd4, 1'b1},
      '{2'b00, 2'b10, 2'b00, 2'b00, 32'h140, 32'h300, 16'd8,  32'h140, 32'h308, 8'd2, 1'b1},
      '{2'b01, 2'b10, 2'b00, 2'b01, 32'h040, 32'h400, 16'd3,  32'h040, 32'h403, 8'd3, 1'b1},
      '{2'b10, 2'b00, 2'b10, 2'b10, 32'h180, 32'h044, 16'd6,  32'h186, 32'h044, 8'd3, 1'b0},
      '{2'b11, 2'b01, 2'b01, 2'b00, 32'h700, 32'h800, 16'd5,  32'h708, 32'h808, 8'd2, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, per_ack, bus_req, bus_we;
   logic        per_req = 1'b0;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic [1:0]  bus_size;
   logic        bus_ack, bus_err;

   int checks = 0, failures = 0;
   int rd_count = 0, wr_count = 0, pack_count = 0;
   logic [31:0] last_wdata = '0;
   logic        err_arm = 1'b0;

   always #2 clk = ~clk;

   dma_xfer_channel u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .per_req(per_req), .per_ack(per_ack), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
      .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
   );

   // Memory and peripheral responder: single-cycle accesses.
   initial begin
      bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
      forever begin
         @(negedge clk);
         bus_err   = bus_req && err_arm;
         bus_ack   = bus_req && !err_arm;
         bus_rdata = bus_addr ^ PAT;
         if (bus_req && err_arm) err_arm = 1'b0;
         if (bus_req && bus_ack && !bus_we) rd_count++;
         if (bus_req && bus_ack && bus_we) begin
            wr_count++;
            last_wdata = bus_wdata;
         end
         #1;
         if (per_ack) pack_count++;
      end
   end

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic wait_bit(input int b, input int limit);
      logic [31:0] s;
      for (int i = 0; i < limit; i++) begin
         rd(5, s);
         if (s[b]) break;
      end
   endtask

   function automatic logic [31:0] mk(input logic en, input logic sr, input logic [1:0] mode,
         input logic [1:0] sd, input logic [1:0] dd, input logic [1:0] wd, input logic tg);
      return {21'd0, tg, wd, dd, sd, mode, sr, en};
   endfunction

   function automatic int step_of(input logic [1:0] mode, input logic [1:0] wd);
      if (mode == 2'b01 || mode == 2'b10)
         return (wd == 2'b01) ? 1 : (wd == 2'b10) ? 2 : 4;
      return 4;
   endfunction

   initial begin
      logic [31:0] d, last_rd;
      int w0, r0, p0;
      bit seen;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(0, d); chk("R1 ctrl", d, 0);
      rd(5, d); chk("R1 status", d, 0);
      rd(8, d); chk("R1 count", d, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 bus_req", {31'd0, bus_req}, 0);

      // R8: trigger with enable low starts nothing
      wr(3, 8); wr(1, 32'h900); wr(2, 32'hA00);
      r0 = rd_count;
      wr(0, mk(0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
      repeat (10) @(negedge clk);
      chk("R8 no reads while disabled", rd_count - r0, 0);
      chk("R8 bus idle while disabled", {31'd0, bus_req}, 0);

      // Vector table: R2 R3 R4 R5 R7
      for (int v = 0; v < NV; v++) begin
         wr(1, VEC[v].src); wr(2, VEC[v].dst); wr(3, 32'(VEC[v].cnt));
         wr(4, 32'h2); wr(5, 32'hF);
         per_req = (VEC[v].mode == 2'b01 || VEC[v].mode == 2'b10);
         w0 = wr_count; p0 = pack_count;
         wr(0, mk(1, 0, VEC[v].mode, VEC[v].sdir, VEC[v].ddir, VEC[v].wid, 1));
         wait_bit(1, 200);
         rd(5, d); chk($sformatf("R4 v%0d done flag", v), 32'(d[1]), 1);
         chk($sformatf("R7 v%0d half flag", v), 32'(d[3]), 32'(VEC[v].ehalf));
         rd(6, d); chk($sformatf("R3 v%0d cur src", v), d, VEC[v].esrc);
         rd(7, d); chk($sformatf("R3 v%0d cur dst", v), d, VEC[v].edst);
         rd(8, d); chk($sformatf("R4 v%0d cur count", v), d, 0);
         rd(0, d); chk($sformatf("R4 v%0d trigger cleared", v), 32'(d[10]), 0);
         chk($sformatf("R2 v%0d beats", v), wr_count - w0, 32'(VEC[v].ebeats));
         last_rd = (VEC[v].sdir == 2'b10) ? VEC[v].src
                   : VEC[v].esrc - 32'(step_of(VEC[v].mode, VEC[v].wid));
         chk($sformatf("R2 v%0d last data", v), last_wdata, last_rd ^ PAT);
         chk($sformatf("R5 v%0d peripheral acks", v), pack_count - p0,
             per_req ? 32'(VEC[v].ebeats) : 0);
         chk($sformatf("R11 v%0d irq on done", v), {31'd0, irq}, 1);
         if (v == 0) begin
            wr(5, 32'h0); rd(5, d); chk("R11 write 0 keeps flag", 32'(d[1]), 1);
         end
         wr(5, 32'h2); rd(5, d); chk($sformatf("R11 v%0d w1c", v), 32'(d[1]), 0);
         chk($sformatf("R11 v%0d irq drops", v), {31'd0, irq}, 0);
      end

      // R5: peripheral mode waits for the request
      per_req = 1'b0;
      wr(1, 32'h60); wr(2, 32'hB00); wr(3, 4); wr(5, 32'hF);
      r0 = rd_count; p0 = pack_count;
      wr(0, mk(1, 0, 2'b01, 2'b10, 2'b00, 2'b00, 1));
      repeat (10) @(negedge clk);
      chk("R5 no beat without request", rd_count - r0, 0);
      per_req = 1'b1;
      wait_bit(1, 100);
      chk("R5 one ack after request", pack_count - p0, 1);

      // R6 R7: wrap-around restarts without a trigger
      per_req = 1'b0;
      wr(1, 32'h500); wr(2, 32'h600); wr(3, 16); wr(4, 32'hC); wr(5, 32'hF);
      w0 = wr_count;
      wr(0, mk(1, 0, 2'b00, 2'b11, 2'b11, 2'b00, 1));
      wait_bit(2, 100);
      rd(5, d);
      chk("R6 wrap flag", 32'(d[2]), 1);
      chk("R7 half flag in wrap", 32'(d[3]), 1);
      chk("R6 done not set in wrap", 32'(d[1]), 0);
      chk("R11 irq from wrap", {31'd0, irq}, 1);
      repeat (12) @(negedge clk);
      chk("R6 second lap runs", 32'(wr_count - w0 > 4), 1);
      rd(0, d); chk("R6 trigger kept in wrap", 32'(d[10]), 1);
      // R8: disabling stops the lap
      wr(0, mk(0, 0, 2'b00, 2'b11, 2'b11, 2'b00, 1));
      repeat (6) @(negedge clk);
      w0 = wr_count;
      repeat (20) @(negedge clk);
      chk("R8 no writes after disable", wr_count - w0, 0);
      chk("R8 bus idle after disable", {31'd0, bus_req}, 0);

      // R11: hardware set collides with a software clear
      wr(4, 32'h0); wr(3, 4); wr(5, 32'hF);
      wr(0, mk(1, 0, 2'b00, 2'b11, 2'b11, 2'b00, 1));
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h4;
      seen = 0;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         #1 if (reg_rdata[2]) seen = 1;
      end
      reg_we = 1'b0;
      chk("R11 set wins over clear", 32'(seen), 1);
      wr(0, mk(0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 0));
      repeat (6) @(negedge clk);

      // R9: bus error aborts and locks
      wr(1, 32'h900); wr(2, 32'hA00); wr(3, 8); wr(5, 32'hF);
      err_arm = 1'b1;
      w0 = wr_count;
      wr(0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
      wait_bit(0, 100);
      rd(5, d); chk("R9 abort flag", 32'(d[0]), 1);
      rd(0, d); chk("R9 trigger cleared", 32'(d[10]), 0);
      chk("R9 no write after error", wr_count - w0, 0);
      chk("R9 bus idle", {31'd0, bus_req}, 0);
      r0 = rd_count;
      wr(0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
      repeat (10) @(negedge clk);
      chk("R9 locked until soft reset", rd_count - r0, 0);

      // R10: soft reset
      wr(0, mk(1, 1, 2'b00, 2'b00, 2'b00, 2'b00, 0));
      repeat (6) @(negedge clk);
      rd(0, d); chk("R10 ctrl kept, bit self-clears", d, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 0));
      rd(6, d); chk("R10 current source cleared", d, 0);
      rd(8, d); chk("R10 current count cleared", d, 0);
      wr(5, 32'hF);
      w0 = wr_count;
      wr(0, mk(1, 0, 2'b00, 2'b00, 2'b00, 2'b00, 1));
      wait_bit(1, 100);
      chk("R10 runs again after soft reset", wr_count - w0, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule